// File: doc/BRIEF.md
# Alternating Bit Transmit Controller

This block is the sending end of a stop-and-wait link that uses a one-bit sequence flag. It accepts 8-bit words from a local producer. Each word goes out as a tagged frame in a single-entry outgoing slot. The flag's value selects the frame tag, so the far end can tell a fresh word from a repeat. A downstream medium empties the slot when it carries the frame away.

Acknowledgements come back through a single-entry return slot held inside the block. A return medium fills that slot only while it is empty. The controller drains the slot while it waits for an answer. An answer that carries the current flag value completes the word: the flag flips and a new word is taken from the producer. An answer that carries the other value, or one marked as corrupted, makes the controller send the same frame again. An empty return slot leaves the controller waiting indefinitely. There is no timer.

Top module: `abp_tx_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the outgoing slot tag is 00 (empty), `usr_ready` is 0 and the return slot tag is 00. The first frame carries tag 01 and the `PRELOAD` word (default 8'h00).
- R2: After reset is released, the outgoing slot stays empty after the first rising edge. The first frame becomes visible after the second rising edge, because the controller passes through its fetch step into its transmit step.
- R3: In the transmit step, the controller writes a frame only when the outgoing slot is empty. The tag is 01 when the sequence flag is 0 and 10 when it is 1, and the data is the held word. While the slot is occupied, the controller waits and the slot tag and data stay unchanged.
- R4: A return tag that matches the flag (01 with flag 0, 10 with flag 1) seen while waiting raises `usr_ready` in that cycle and flips the flag. The next frame therefore carries the other data tag.
- R5: A return tag of the opposite parity, or 11 (corrupted), seen while waiting causes the same tag and word to be sent again. The flag does not change and `usr_ready` stays 0.
- R6: While the controller waits and the return slot is empty, no frame is written and `usr_ready` stays 0.
- R7: In every waiting cycle that finds the return slot occupied, the controller empties that slot. Outside the waiting step, a stored return tag is kept.
- R8: `ack_put` fills the return slot only when the slot is empty. A put while it is occupied is ignored.
- R9: The held word is replaced by `usr_word` only in a cycle where both `usr_ready` and `usr_valid` are 1. Otherwise the previous word is kept and sent again under the new tag.
- R10: `tx_take` empties an occupied outgoing slot on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usr_valid | input | 1 | Producer offers `usr_word` |
| usr_word | input | WORD_W | Word offered by the producer |
| usr_ready | output | 1 | Word accepted this cycle (matching answer) |
| tx_tag | output | 2 | Outgoing slot tag: 00 empty, 01 flag-0 data, 10 flag-1 data, 11 corrupted |
| tx_data | output | WORD_W | Outgoing slot data |
| tx_take | input | 1 | Medium removes the outgoing frame |
| ack_put | input | 1 | Return medium offers a tag |
| ack_in | input | 2 | Offered return tag: 00 empty, 01 flag-0 answer, 10 flag-1 answer, 11 corrupted |
| ack_slot_tag | output | 2 | Current content of the return slot |

## Verification
The hardest situation to reach is an answer that arrives while the controller is blocked in its transmit step. In that case the answer must stay in the return slot, and later it is applied to the frame that has not yet been written. To reach it, the bench stops taking frames. It answers the stuck frame so that the controller moves on and blocks on the full slot. Then it stores a new answer, tries to overwrite it, and only after that resumes taking frames. It checks that the stored answer completes the newly written frame at once and that the next word follows. Retries for a wrong parity and for a corrupted answer, and a matching answer with no word on offer, are driven through the same scoreboard.

// File: rtl/abp_tx_pkg.sv
package abp_tx_pkg;

    localparam int TAG_W = 2;

    typedef enum logic [1:0] {
        FR_EMPTY   = 2'b00,
        FR_SEQ0    = 2'b01,
        FR_SEQ1    = 2'b10,
        FR_CORRUPT = 2'b11
    } frame_tag_e;

    typedef enum logic [1:0] {
        AK_EMPTY   = 2'b00,
        AK_SEQ0    = 2'b01,
        AK_SEQ1    = 2'b10,
        AK_CORRUPT = 2'b11
    } ack_tag_e;

    typedef enum logic [1:0] {
        TX_GET  = 2'b00,
        TX_SEND = 2'b01,
        TX_WAIT = 2'b10
    } tx_state_e;

    typedef enum logic [1:0] {
        AV_NONE  = 2'b00,
        AV_MATCH = 2'b01,
        AV_RETRY = 2'b10
    } ack_verdict_e;

    function automatic frame_tag_e frame_tag_for(input logic seq);
        return seq ? FR_SEQ1 : FR_SEQ0;
    endfunction

    function automatic ack_verdict_e judge_ack(input logic seq, input ack_tag_e t);
        ack_verdict_e v;
        case (t)
            AK_EMPTY: v = AV_NONE;
            AK_SEQ0:  v = seq ? AV_RETRY : AV_MATCH;
            AK_SEQ1:  v = seq ? AV_MATCH : AV_RETRY;
            default:  v = AV_RETRY;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/abp_tx_seq_fsm.sv
module abp_tx_seq_fsm
    import abp_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      slot_empty,
    input  ack_tag_e  ack_tag,
    output tx_state_e state,
    output logic      seq_bit,
    output logic      write_en,
    output logic      accept,
    output logic      consume
);

    tx_state_e    state_nxt;
    ack_verdict_e verdict;

    always_comb begin
        verdict   = judge_ack(seq_bit, ack_tag);
        state_nxt = state;
        write_en  = 1'b0;
        accept    = 1'b0;
        case (state)
            TX_GET:  state_nxt = TX_SEND;
            TX_SEND: begin
                if (slot_empty) begin
                    write_en  = 1'b1;
                    state_nxt = TX_WAIT;
                end
            end
            TX_WAIT: begin
                case (verdict)
                    AV_MATCH: begin
                        accept    = 1'b1;
                        state_nxt = TX_GET;
                    end
                    AV_RETRY: state_nxt = TX_SEND;
                    default:  state_nxt = TX_WAIT;
                endcase
            end
            default: state_nxt = TX_GET;
        endcase
    end

    assign consume = (state == TX_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_GET;
            seq_bit <= 1'b0;
        end else begin
            state <= state_nxt;
            if (accept) begin
                seq_bit <= ~seq_bit;
            end
        end
    end

endmodule

// File: rtl/abp_tx_frame_slot.sv
module abp_tx_frame_slot
    import abp_tx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  frame_tag_e        wr_tag,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    output frame_tag_e        tag_q,
    output logic [WORD_W-1:0] data_q,
    output logic              empty
);

    assign empty = (tag_q == FR_EMPTY);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= FR_EMPTY;
            data_q <= '0;
        end else if (wr_en && empty) begin
            tag_q  <= wr_tag;
            data_q <= wr_data;
        end else if (take && !empty) begin
            tag_q <= FR_EMPTY;
        end
    end

endmodule

// File: rtl/abp_tx_ack_slot.sv
module abp_tx_ack_slot
    import abp_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     consume,
    input  logic     put,
    input  ack_tag_e put_tag,
    output ack_tag_e tag_q
);

    logic occupied;
    assign occupied = (tag_q != AK_EMPTY);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= AK_EMPTY;
        end else if (consume && occupied) begin
            tag_q <= AK_EMPTY;
        end else if (put && !occupied) begin
            tag_q <= put_tag;
        end
    end

endmodule

// File: rtl/abp_tx_word_reg.sv
module abp_tx_word_reg #(
    parameter int                WORD_W  = 8,
    parameter logic [WORD_W-1:0] PRELOAD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              valid,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= PRELOAD;
        end else if (load && valid) begin
            word_q <= word_in;
        end
    end

endmodule

// File: rtl/abp_tx_ctrl.sv
module abp_tx_ctrl
    import abp_tx_pkg::*;
#(
    parameter int                WORD_W  = 8,
    parameter logic [WORD_W-1:0] PRELOAD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              usr_valid,
    input  logic [WORD_W-1:0] usr_word,
    output logic              usr_ready,
    output logic [TAG_W-1:0]  tx_tag,
    output logic [WORD_W-1:0] tx_data,
    input  logic              tx_take,
    input  logic              ack_put,
    input  logic [TAG_W-1:0]  ack_in,
    output logic [TAG_W-1:0]  ack_slot_tag
);

    tx_state_e         fsm_state;
    logic              seq_bit;
    logic              write_en;
    logic              accept;
    logic              consume;
    logic              slot_empty;
    frame_tag_e        slot_tag;
    ack_tag_e          ack_tag;
    logic [WORD_W-1:0] held_word;

    abp_tx_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .slot_empty (slot_empty),
        .ack_tag    (ack_tag),
        .state      (fsm_state),
        .seq_bit    (seq_bit),
        .write_en   (write_en),
        .accept     (accept),
        .consume    (consume)
    );

    abp_tx_frame_slot #(.WORD_W(WORD_W)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (write_en),
        .wr_tag  (frame_tag_for(seq_bit)),
        .wr_data (held_word),
        .take    (tx_take),
        .tag_q   (slot_tag),
        .data_q  (tx_data),
        .empty   (slot_empty)
    );

    abp_tx_ack_slot u_ack (
        .clk     (clk),
        .rst     (rst),
        .consume (consume),
        .put     (ack_put),
        .put_tag (ack_tag_e'(ack_in)),
        .tag_q   (ack_tag)
    );

    abp_tx_word_reg #(.WORD_W(WORD_W), .PRELOAD(PRELOAD)) u_word (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .valid   (usr_valid),
        .word_in (usr_word),
        .word_q  (held_word)
    );

    assign usr_ready    = accept;
    assign tx_tag       = slot_tag;
    assign ack_slot_tag = ack_tag;

endmodule

// File: rtl/abp_tx_ctrl_chk.sv
module abp_tx_ctrl_chk
    import abp_tx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              usr_ready,
    input logic [1:0]        tx_tag,
    input logic [WORD_W-1:0] tx_data,
    input logic              tx_take,
    input logic [1:0]        ack_slot_tag,
    input tx_state_e         fsm_state,
    input logic              seq_bit
);

    // R3: an occupied, untaken frame does not move
    a_r3_slot_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_tag != 2'b00 && !tx_take) |=> ($stable(tx_tag) && $stable(tx_data)));

    // R3: a freshly written frame carries the flag's data tag
    a_r3_tag_parity: assert property (@(posedge clk) disable iff (rst)
        (tx_tag != 2'b00 && $past(tx_tag) == 2'b00) |-> (tx_tag == (seq_bit ? 2'b10 : 2'b01)));

    // R10: taking an occupied slot empties it
    a_r10_take_empties: assert property (@(posedge clk) disable iff (rst)
        (tx_tag != 2'b00 && tx_take) |=> (tx_tag == 2'b00));

    // R7: waiting drains an occupied return slot
    a_r7_wait_consumes: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == TX_WAIT && ack_slot_tag != 2'b00) |=> (ack_slot_tag == 2'b00));

    // R8: outside waiting, an occupied return slot keeps its content
    a_r8_full_holds: assert property (@(posedge clk) disable iff (rst)
        (fsm_state != TX_WAIT && ack_slot_tag != 2'b00) |=> $stable(ack_slot_tag));

    // R4: acceptance needs a data answer in the slot
    a_r4_ready_match: assert property (@(posedge clk) disable iff (rst)
        usr_ready |-> (ack_slot_tag == 2'b01 || ack_slot_tag == 2'b10));

    // R4: acceptance flips the flag
    a_r4_toggle: assert property (@(posedge clk) disable iff (rst)
        usr_ready |=> (seq_bit != $past(seq_bit)));

endmodule

bind abp_tx_ctrl abp_tx_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .usr_ready    (usr_ready),
    .tx_tag       (tx_tag),
    .tx_data      (tx_data),
    .tx_take      (tx_take),
    .ack_slot_tag (ack_slot_tag),
    .fsm_state    (fsm_state),
    .seq_bit      (seq_bit)
);

// File: tb/abp_tx_ctrl_test.sv
`timescale 1ns/1ps
module abp_tx_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       usr_valid = 1'b0;
    logic [7:0] usr_word = 8'h00;
    logic       usr_ready;
    logic [1:0] tx_tag;
    logic [7:0] tx_data;
    logic       tx_take = 1'b0;
    logic       ack_put = 1'b0;
    logic [1:0] ack_in = 2'b00;
    logic [1:0] ack_slot_tag;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  take_en = 1'b1;

    logic [9:0] exp_q[$];
    string      req_q[$];

    always #2 clk = ~clk;

    abp_tx_ctrl uut (
        .clk          (clk),
        .rst          (rst),
        .usr_valid    (usr_valid),
        .usr_word     (usr_word),
        .usr_ready    (usr_ready),
        .tx_tag       (tx_tag),
        .tx_data      (tx_data),
        .tx_take      (tx_take),
        .ack_put      (ack_put),
        .ack_in       (ack_in),
        .ack_slot_tag (ack_slot_tag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_frame(input logic [1:0] tag, input logic [7:0] data, input string req);
        exp_q.push_back({tag, data});
        req_q.push_back(req);
    endtask

    // monitor: takes frames from the outgoing slot and compares them
    always @(negedge clk) begin
        if (rst) begin
            tx_take = 1'b0;
        end else if (take_en && tx_tag != 2'b00) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected frame", {22'd0, tx_tag, tx_data}, 32'd0);
            end else begin
                logic [9:0] e;
                string      r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk({tx_tag, tx_data} == e, r, {22'd0, tx_tag, tx_data}, {22'd0, e});
            end
            tx_take = 1'b1;
        end else begin
            tx_take = 1'b0;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drain(input string req);
        int waited = 0;
        while (exp_q.size() != 0 && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        @(negedge clk);
    endtask

    task automatic put_ack(input logic [1:0] tag, input bit valid, input logic [7:0] word,
                           input bit exp_ready, input string req);
        @(negedge clk);
        ack_put   = 1'b1;
        ack_in    = tag;
        usr_valid = valid;
        usr_word  = word;
        @(posedge clk);
        @(negedge clk);
        ack_put = 1'b0;
        chk(usr_ready == exp_ready, req, usr_ready, exp_ready);
        @(posedge clk);
        @(negedge clk);
        usr_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        cycles(3);
        // R1 reset values
        chk(tx_tag == 2'b00, "R1 tx_tag", tx_tag, 0);
        chk(usr_ready == 1'b0, "R1 usr_ready", usr_ready, 0);
        chk(ack_slot_tag == 2'b00, "R1 ack slot", ack_slot_tag, 0);
        push_frame(2'b01, 8'h00, "R1 first frame");
        take_en = 1'b0;
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(tx_tag == 2'b00, "R2 empty after first edge", tx_tag, 0);
        @(posedge clk); @(negedge clk);
        chk(tx_tag == 2'b01, "R2 frame after second edge", tx_tag, 1);
        take_en = 1'b1;
        drain("R1 drain");

        // R5 wrong parity, then corrupted answer
        push_frame(2'b01, 8'h00, "R5 resend after wrong parity");
        put_ack(2'b10, 1'b1, 8'h11, 1'b0, "R5 no ready on wrong parity");
        drain("R5 drain");
        push_frame(2'b01, 8'h00, "R5 resend after corrupted");
        put_ack(2'b11, 1'b1, 8'h22, 1'b0, "R5 no ready on corrupted");
        drain("R5 drain2");

        // R6 empty return slot: nothing happens
        chk(tx_tag == 2'b00, "R10 slot emptied by take", tx_tag, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(usr_ready == 1'b0 && tx_tag == 2'b00, "R6 idle while waiting",
                {usr_ready, tx_tag}, 0);
        end

        // R4 matching answer, frame left in slot
        take_en = 1'b0;
        put_ack(2'b01, 1'b1, 8'hA5, 1'b1, "R4 ready on matching answer");
        cycles(4);
        chk(tx_tag == 2'b10, "R4 tag toggled", tx_tag, 2);
        chk(tx_data == 8'hA5, "R9 word loaded", tx_data, 8'hA5);
        cycles(6);
        chk(tx_tag == 2'b10 && tx_data == 8'hA5, "R3 frame held", {tx_tag, tx_data}, {2'b10, 8'hA5});

        // answer the held frame so the controller blocks on the full slot
        put_ack(2'b10, 1'b1, 8'h3C, 1'b1, "R4 ready on second match");
        cycles(3);
        chk(tx_tag == 2'b10 && tx_data == 8'hA5, "R3 blocked on full slot", {tx_tag, tx_data}, {2'b10, 8'hA5});

        // R7 answer kept outside waiting; R8 second put ignored
        put_ack(2'b01, 1'b0, 8'h00, 1'b0, "R7 no ready while blocked");
        cycles(4);
        chk(ack_slot_tag == 2'b01, "R7 answer retained", ack_slot_tag, 1);
        put_ack(2'b11, 1'b0, 8'h00, 1'b0, "R8 no ready on ignored put");
        chk(ack_slot_tag == 2'b01, "R8 put ignored while full", ack_slot_tag, 1);

        usr_word  = 8'hE7;
        usr_valid = 1'b1;
        push_frame(2'b10, 8'hA5, "R3 held frame released");
        push_frame(2'b01, 8'h3C, "R7 stored answer applied");
        push_frame(2'b10, 8'hE7, "R4 next word after stored answer");
        take_en = 1'b1;
        drain("R7 drain");
        usr_valid = 1'b0;
        chk(ack_slot_tag == 2'b00, "R7 answer consumed", ack_slot_tag, 0);

        // R9 matching answer without a word on offer keeps the word
        push_frame(2'b01, 8'hE7, "R9 word kept");
        put_ack(2'b10, 1'b0, 8'h99, 1'b1, "R9 ready without valid");
        drain("R9 drain");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule